// File: doc/BRIEF.md
# DDR SDRAM Power-Up Initialization Sequencer

This block sits on the controller side of a DDR SDRAM interface and walks the memory through its mandatory bring-up. It starts when reset is released and holds clock enable low for a stabilization period given in clock cycles. It then raises clock enable on a NOP and issues a fixed series of commands. The first is a precharge of all banks. Next come an extended mode register write that enables the DLL and a mode register write that resets the DLL. A second all-bank precharge follows, then a configurable number of auto-refresh commands. The series ends with a mode register write that clears the DLL reset bit and sets the operating mode. Each gap between commands is set by a parameter: tRP, tRFC, tMRD and the DLL lock count.

The block raises `init_done` once the last mode register wait has run out and the DLL lock window has also passed. From then on the command bus rests on NOP and a normal command scheduler can take over. The FSM states are S_PWR_WAIT, S_CKE_UP, S_PRE_A, S_PRE_A_WAIT, S_EMRS_DLL, S_EMRS_WAIT, S_MRS_RST, S_MRS_RST_WAIT, S_PRE_B, S_PRE_B_WAIT, S_REF, S_REF_WAIT, S_MRS_RUN, S_MRS_RUN_WAIT and S_READY, in that order. Each wait state moves on when the shared timer reaches zero. S_REF_WAIT returns to S_REF until the refresh count is reached. S_MRS_RUN_WAIT also waits for the DLL lock counter. S_READY is terminal. Every output is registered.

Top module: `ddr_init_seq`

## Requirements
- R1: While reset is held, and for exactly T_POWERUP sampled cycles after it is released, `cke` is 0, the bus carries NOP and `init_done` is 0. Reset applied at any point restarts the whole sequence. Command encoding {cs_n,ras_n,cas_n,we_n}: NOP=0111, PRECHARGE=0010, AUTO-REFRESH=0001, mode register write=0000.
- R2: The first cycle with `cke` high carries NOP. Once high, `cke` never drops until the next reset.
- R3: Exactly 5+N_REF commands are issued, in this order: PRECHARGE, EMRS, MRS (DLL reset), PRECHARGE, N_REF x AUTO-REFRESH, MRS (run). Only the four encodings of R1 ever appear.
- R4: Each PRECHARGE drives A10=1 (all banks) and BA=00.
- R5: The DLL-enable EMRS drives BA=01 (BA0 high, BA1 low) and A11:A0 all zero (A0=0 enables the DLL).
- R6: The DLL-reset MRS drives BA=00, A8=1, A2:A0=burst length code, A3=burst type, A6:A4=CAS latency code, and all other address bits 0.
- R7: The final MRS drives BA=00, A8=0 and the same mode fields as R6.
- R8: Counting from issue cycle to issue cycle, a PRECHARGE is followed by at least T_RP cycles and an AUTO-REFRESH by at least T_RFC cycles before the next command. A mode register write is followed by at least T_MRD cycles before the next command or before `init_done`.
- R9: `init_done` rises no fewer than T_DLL cycles after the DLL-reset MRS, and no fewer than T_MRD cycles after the final MRS.
- R10: Once `init_done` is high it stays high, `cke` stays high and the bus stays on NOP until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cke | output | 1 | Clock enable to the memory |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row address strobe, active low |
| cas_n | output | 1 | Column address strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | 2 | Bank address |
| addr | output | 12 | Address bus A11:A0 |
| init_done | output | 1 | High once initialization is complete |

## Verification
The bench sets the DLL lock window longer than the remaining command series, so the final gate on `init_done` is the lock counter and not the last mode register wait. A design that ignored the lock count would raise `init_done` too early. The bench logs every non-NOP command with its cycle number. That catches a swapped EMRS/MRS pair, a refresh loop that stops one short or runs one over, and off-by-one waits that shave a cycle from tRP, tRFC or tMRD. It also checks the bank and address values of each mode write, so a mistaken BA0 on the EMRS or an A8 left set in the final MRS would show. A reset applied mid-sequence must bring `cke` back low and replay the full series, which exposes state left over from the first pass.

// File: rtl/ddr_init_pkg.sv
package ddr_init_pkg;

    // {cs_n, ras_n, cas_n, we_n}
    typedef enum logic [3:0] {
        CMD_MRS = 4'b0000,
        CMD_REF = 4'b0001,
        CMD_PRE = 4'b0010,
        CMD_NOP = 4'b0111
    } ddr_cmd_e;

    typedef enum logic [3:0] {
        S_PWR_WAIT,
        S_CKE_UP,
        S_PRE_A,
        S_PRE_A_WAIT,
        S_EMRS_DLL,
        S_EMRS_WAIT,
        S_MRS_RST,
        S_MRS_RST_WAIT,
        S_PRE_B,
        S_PRE_B_WAIT,
        S_REF,
        S_REF_WAIT,
        S_MRS_RUN,
        S_MRS_RUN_WAIT,
        S_READY
    } init_state_e;

    typedef struct packed {
        logic        cke;
        ddr_cmd_e    cmd;
        logic [1:0]  ba;
        logic [11:0] addr;
        logic        done;
    } bus_word_t;

    localparam bus_word_t BUS_IDLE = '{cke: 1'b0, cmd: CMD_NOP, ba: 2'b00,
                                       addr: 12'h000, done: 1'b0};

endpackage

// File: rtl/ddr_init_timer.sv
module ddr_init_timer #(
    parameter int W       = 8,
    parameter int RST_VAL = 0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    localparam logic [W-1:0] RST_CNT = W'(RST_VAL);

    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= RST_CNT;
        else if (load)       cnt <= load_val;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);

    // R8: an idle countdown only moves down by one per cycle
    a_r8_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

    // R8: a load is taken exactly
    a_r8_load_taken: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt == $past(load_val)));

endmodule

// File: rtl/ddr_init_lock_cnt.sv
module ddr_init_lock_cnt #(
    parameter int T_DLL = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic expired
);
    localparam int LW = (T_DLL < 2) ? 1 : $clog2(T_DLL + 1);
    localparam logic [LW-1:0] START_VAL = (T_DLL < 1) ? '0 : LW'(T_DLL - 1);

    logic [LW-1:0] cnt;
    logic          armed;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt   <= '0;
            armed <= 1'b0;
        end else if (start) begin
            cnt   <= START_VAL;
            armed <= 1'b1;
        end else if (cnt != '0) begin
            cnt   <= cnt - 1'b1;
        end
    end

    assign expired = armed && (cnt == '0);

    // R9: once the lock window has run out it stays out until restarted
    a_r9_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (expired && !start) |=> expired);

    // R9: starting the window always clears the expired indication
    a_r9_lock_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (start && T_DLL > 1) |=> !expired);

endmodule

// File: rtl/ddr_init_bus_reg.sv
module ddr_init_bus_reg
    import ddr_init_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  bus_word_t nxt,
    output bus_word_t q
);
    always_ff @(posedge clk) begin
        if (!rst_n) q <= BUS_IDLE;
        else        q <= nxt;
    end

    // R1: clock enable low means the bus rests on NOP
    a_r1_low_cke_nop: assert property (@(posedge clk) disable iff (!rst_n)
        !q.cke |-> (q.cmd == CMD_NOP && !q.done));

    // R2: clock enable never drops once raised
    a_r2_cke_no_fall: assert property (@(posedge clk) disable iff (!rst_n)
        q.cke |=> q.cke);

    // R10: done is sticky and quiet
    a_r10_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        q.done |=> q.done);
    a_r10_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        q.done |-> (q.cke && q.cmd == CMD_NOP));

    // R4: every precharge addresses all banks
    a_r4_pre_all: assert property (@(posedge clk) disable iff (!rst_n)
        (q.cmd == CMD_PRE) |-> (q.addr[10] && q.ba == 2'b00));

    // R3: only one non-NOP command in a row of two cycles
    a_r3_one_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        (q.cmd != CMD_NOP) |=> (q.cmd == CMD_NOP));

endmodule

// File: rtl/ddr_init_seq.sv
module ddr_init_seq
    import ddr_init_pkg::*;
#(
    parameter int         T_POWERUP = 10000,
    parameter int         T_RP      = 3,
    parameter int         T_RFC     = 9,
    parameter int         T_MRD     = 2,
    parameter int         T_DLL     = 200,
    parameter int         N_REF     = 2,
    parameter logic [2:0] BURST_LEN = 3'b001,
    parameter logic       BURST_SEQ = 1'b0,
    parameter logic [2:0] CAS_LAT   = 3'b010
) (
    input  logic        clk,
    input  logic        rst_n,
    output logic        cke,
    output logic        cs_n,
    output logic        ras_n,
    output logic        cas_n,
    output logic        we_n,
    output logic [1:0]  ba,
    output logic [11:0] addr,
    output logic        init_done
);
    localparam int N_REF_EFF = (N_REF < 2) ? 2 : N_REF;
    localparam int PWR_EFF   = (T_POWERUP < 1) ? 1 : T_POWERUP;
    localparam int M1   = (T_RP  > T_RFC) ? T_RP  : T_RFC;
    localparam int M2   = (M1    > T_MRD) ? M1    : T_MRD;
    localparam int TMAX = (M2    > PWR_EFF) ? M2  : PWR_EFF;
    localparam int TW   = $clog2(TMAX + 1);
    localparam int RW   = $clog2(N_REF_EFF + 1);

    // wait-state reload: the issue cycle plus the one-cycle exit count toward the gap
    localparam logic [TW-1:0] LD_RP  = (T_RP  < 2) ? '0 : TW'(T_RP  - 2);
    localparam logic [TW-1:0] LD_RFC = (T_RFC < 2) ? '0 : TW'(T_RFC - 2);
    localparam logic [TW-1:0] LD_MRD = (T_MRD < 2) ? '0 : TW'(T_MRD - 2);

    // A2:A0 burst length, A3 burst type, A6:A4 CAS latency, A8 DLL reset
    localparam logic [11:0] MODE_RUN = {5'b00000, CAS_LAT, BURST_SEQ, BURST_LEN};
    localparam logic [11:0] MODE_RST = MODE_RUN | 12'h100;
    localparam logic [11:0] EMRS_DLL = 12'h000;
    localparam logic [11:0] PRE_ALL  = 12'h400;

    init_state_e   state, state_nxt;
    logic          tmr_load;
    logic [TW-1:0] tmr_val;
    logic          tmr_zero;
    logic          lock_start;
    logic          lock_done;
    logic [RW-1:0] ref_cnt;
    bus_word_t     bus_nxt, bus_q;

    ddr_init_timer #(
        .W       (TW),
        .RST_VAL (PWR_EFF - 1)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    ddr_init_lock_cnt #(
        .T_DLL (T_DLL)
    ) u_lock (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (lock_start),
        .expired (lock_done)
    );

    ddr_init_bus_reg u_bus (
        .clk   (clk),
        .rst_n (rst_n),
        .nxt   (bus_nxt),
        .q     (bus_q)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_PWR_WAIT;
        else        state <= state_nxt;
    end

    // refresh counter
    always_ff @(posedge clk) begin
        if (!rst_n)              ref_cnt <= '0;
        else if (state == S_REF) ref_cnt <= ref_cnt + 1'b1;
    end

    // next state and timer control
    always_comb begin
        state_nxt  = state;
        tmr_load   = 1'b0;
        tmr_val    = '0;
        lock_start = 1'b0;
        unique case (state)
            S_PWR_WAIT:     if (tmr_zero) state_nxt = S_CKE_UP;
            S_CKE_UP:       state_nxt = S_PRE_A;
            S_PRE_A: begin
                tmr_load  = 1'b1;
                tmr_val   = LD_RP;
                state_nxt = S_PRE_A_WAIT;
            end
            S_PRE_A_WAIT:   if (tmr_zero) state_nxt = S_EMRS_DLL;
            S_EMRS_DLL: begin
                tmr_load  = 1'b1;
                tmr_val   = LD_MRD;
                state_nxt = S_EMRS_WAIT;
            end
            S_EMRS_WAIT:    if (tmr_zero) state_nxt = S_MRS_RST;
            S_MRS_RST: begin
                tmr_load   = 1'b1;
                tmr_val    = LD_MRD;
                lock_start = 1'b1;
                state_nxt  = S_MRS_RST_WAIT;
            end
            S_MRS_RST_WAIT: if (tmr_zero) state_nxt = S_PRE_B;
            S_PRE_B: begin
                tmr_load  = 1'b1;
                tmr_val   = LD_RP;
                state_nxt = S_PRE_B_WAIT;
            end
            S_PRE_B_WAIT:   if (tmr_zero) state_nxt = S_REF;
            S_REF: begin
                tmr_load  = 1'b1;
                tmr_val   = LD_RFC;
                state_nxt = S_REF_WAIT;
            end
            S_REF_WAIT: begin
                if (tmr_zero)
                    state_nxt = (ref_cnt == RW'(N_REF_EFF)) ? S_MRS_RUN : S_REF;
            end
            S_MRS_RUN: begin
                tmr_load  = 1'b1;
                tmr_val   = LD_MRD;
                state_nxt = S_MRS_RUN_WAIT;
            end
            S_MRS_RUN_WAIT: if (tmr_zero && lock_done) state_nxt = S_READY;
            S_READY:        state_nxt = S_READY;
            default:        state_nxt = S_PWR_WAIT;
        endcase
    end

    // outputs decoded from the current state, registered in u_bus
    always_comb begin
        bus_nxt     = BUS_IDLE;
        bus_nxt.cke = (state != S_PWR_WAIT);
        unique case (state)
            S_PRE_A, S_PRE_B: begin
                bus_nxt.cmd  = CMD_PRE;
                bus_nxt.addr = PRE_ALL;
            end
            S_EMRS_DLL: begin
                bus_nxt.cmd  = CMD_MRS;
                bus_nxt.ba   = 2'b01;
                bus_nxt.addr = EMRS_DLL;
            end
            S_MRS_RST: begin
                bus_nxt.cmd  = CMD_MRS;
                bus_nxt.addr = MODE_RST;
            end
            S_REF:     bus_nxt.cmd = CMD_REF;
            S_MRS_RUN: begin
                bus_nxt.cmd  = CMD_MRS;
                bus_nxt.addr = MODE_RUN;
            end
            S_READY:   bus_nxt.done = 1'b1;
            default:   bus_nxt.cmd = CMD_NOP;
        endcase
    end

    assign cke       = bus_q.cke;
    assign {cs_n, ras_n, cas_n, we_n} = bus_q.cmd;
    assign ba        = bus_q.ba;
    assign addr      = bus_q.addr;
    assign init_done = bus_q.done;

    // R9: ready is only reached with the DLL lock window spent
    a_r9_ready_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_READY) |-> lock_done);

    // R3: the refresh loop never runs past its count
    a_r3_ref_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_REF) |-> (ref_cnt < RW'(N_REF_EFF)));

    // R6: the DLL-reset write starts the lock window
    a_r6_lock_begins: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_MRS_RST) |=> (state == S_MRS_RST_WAIT && !lock_done));

endmodule

// File: tb/ddr_init_seq_test.sv
module ddr_init_seq_test;

    localparam int         P_PWR = 40;
    localparam int         P_RP  = 3;
    localparam int         P_RFC = 7;
    localparam int         P_MRD = 2;
    localparam int         P_DLL = 60;
    localparam int         P_REF = 3;
    localparam logic [2:0] P_BL  = 3'b010;
    localparam logic       P_BT  = 1'b1;
    localparam logic [2:0] P_CL  = 3'b011;
    localparam logic [11:0] RUN_WORD = {5'b0, P_CL, P_BT, P_BL};
    localparam logic [11:0] RST_WORD = RUN_WORD | 12'h100;

    localparam logic [3:0] C_NOP = 4'b0111;
    localparam logic [3:0] C_PRE = 4'b0010;
    localparam logic [3:0] C_REF = 4'b0001;
    localparam logic [3:0] C_MRS = 4'b0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cke, cs_n, ras_n, cas_n, we_n, init_done;
    logic [1:0]  ba;
    logic [11:0] addr;

    always #10 clk = ~clk;

    ddr_init_seq #(
        .T_POWERUP (P_PWR), .T_RP (P_RP), .T_RFC (P_RFC), .T_MRD (P_MRD),
        .T_DLL (P_DLL), .N_REF (P_REF),
        .BURST_LEN (P_BL), .BURST_SEQ (P_BT), .CAS_LAT (P_CL)
    ) uut (
        .clk (clk), .rst_n (rst_n), .cke (cke), .cs_n (cs_n), .ras_n (ras_n),
        .cas_n (cas_n), .we_n (we_n), .ba (ba), .addr (addr), .init_done (init_done)
    );

    int checks = 0;
    int bad    = 0;

    // monitor state, cleared while reset is low
    int          n_smp, n_low, n_log, done_at, n_illegal, n_cke_drop, n_after_bad;
    logic [3:0]  first_hi_cmd;
    logic        seen_hi, seen_done;
    int          log_n  [0:31];
    logic [3:0]  log_c  [0:31];
    logic [1:0]  log_ba [0:31];
    logic [11:0] log_a  [0:31];

    wire [3:0] cmd_now = {cs_n, ras_n, cas_n, we_n};

    always @(negedge clk) begin
        if (!rst_n) begin
            n_smp = 0; n_low = 0; n_log = 0; done_at = -1; n_illegal = 0;
            n_cke_drop = 0; n_after_bad = 0; seen_hi = 1'b0; seen_done = 1'b0;
            first_hi_cmd = 4'hF;
        end else begin
            n_smp++;
            if (!cke) begin
                n_low++;
                if (seen_hi) n_cke_drop++;
            end else if (!seen_hi) begin
                seen_hi = 1'b1;
                first_hi_cmd = cmd_now;
            end
            if (cmd_now != C_NOP && cmd_now != C_PRE && cmd_now != C_REF && cmd_now != C_MRS)
                n_illegal++;
            if (cmd_now != C_NOP && n_log < 32) begin
                log_n[n_log]  = n_smp;
                log_c[n_log]  = cmd_now;
                log_ba[n_log] = ba;
                log_a[n_log]  = addr;
                n_log++;
            end
            if (seen_done && (!init_done || !cke || cmd_now != C_NOP)) n_after_bad++;
            if (init_done && !seen_done) begin
                seen_done = 1'b1;
                done_at = n_smp;
                if (cmd_now != C_NOP || !cke) n_after_bad++;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    endtask

    task automatic wait_done();
        for (int i = 0; i < 3000 && !init_done; i++) @(negedge clk);
        @(negedge clk);
        chk(init_done === 1'b1, "R10", "init_done reached", int'(init_done), 1);
    endtask

    task automatic test_reset_state();
        rst_n <= 1'b0;
        repeat (3) @(negedge clk);
        chk(cke === 1'b0, "R1", "cke in reset", int'(cke), 0);
        chk(cmd_now === C_NOP, "R1", "cmd in reset", int'(cmd_now), int'(C_NOP));
        chk(init_done === 1'b0, "R1", "done in reset", int'(init_done), 0);
        rst_n <= 1'b1;
    endtask

    task automatic test_powerup();
        chk(n_low == P_PWR, "R1", "cycles with cke low", n_low, P_PWR);
        chk(first_hi_cmd == C_NOP, "R2", "cmd on cke rise", int'(first_hi_cmd), int'(C_NOP));
        chk(n_cke_drop == 0, "R2", "cke drops", n_cke_drop, 0);
    endtask

    task automatic test_order();
        int exp_c;
        chk(n_log == 5 + P_REF, "R3", "command count", n_log, 5 + P_REF);
        chk(n_illegal == 0, "R3", "illegal encodings", n_illegal, 0);
        for (int i = 0; i < n_log && i < 5 + P_REF; i++) begin
            if (i == 0 || i == 3)            exp_c = int'(C_PRE);
            else if (i >= 4 && i < 4 + P_REF) exp_c = int'(C_REF);
            else                              exp_c = int'(C_MRS);
            chk(int'(log_c[i]) == exp_c, "R3", $sformatf("cmd #%0d", i), int'(log_c[i]), exp_c);
        end
    endtask

    task automatic test_fields();
        if (n_log < 5 + P_REF) return;
        chk(log_a[0][10] && log_ba[0] == 2'b00, "R4", "first precharge A10/BA",
            int'({log_ba[0], log_a[0]}), int'({2'b00, 12'h400}));
        chk(log_a[3][10] && log_ba[3] == 2'b00, "R4", "second precharge A10/BA",
            int'({log_ba[3], log_a[3]}), int'({2'b00, 12'h400}));
        chk(log_ba[1] == 2'b01, "R5", "EMRS bank", int'(log_ba[1]), 1);
        chk(log_a[1] == 12'h000, "R5", "EMRS address", int'(log_a[1]), 0);
        chk(log_ba[2] == 2'b00, "R6", "DLL-reset MRS bank", int'(log_ba[2]), 0);
        chk(log_a[2] == RST_WORD, "R6", "DLL-reset MRS address", int'(log_a[2]), int'(RST_WORD));
        chk(log_ba[4+P_REF] == 2'b00, "R7", "final MRS bank", int'(log_ba[4+P_REF]), 0);
        chk(log_a[4+P_REF] == RUN_WORD, "R7", "final MRS address",
            int'(log_a[4+P_REF]), int'(RUN_WORD));
    endtask

    task automatic test_gaps();
        int need, gap;
        for (int i = 0; i + 1 < n_log; i++) begin
            need = (log_c[i] == C_PRE) ? P_RP : (log_c[i] == C_REF) ? P_RFC : P_MRD;
            gap  = log_n[i+1] - log_n[i];
            chk(gap >= need, "R8", $sformatf("gap after cmd #%0d", i), gap, need);
        end
        if (n_log > 0) begin
            gap = done_at - log_n[n_log-1];
            chk(gap >= P_MRD, "R8", "final MRS to done", gap, P_MRD);
        end
    endtask

    task automatic test_done_timing();
        int gap;
        if (n_log < 3) return;
        gap = done_at - log_n[2];
        chk(gap >= P_DLL, "R9", "DLL reset to done", gap, P_DLL);
        chk(gap <= P_DLL + 4, "R9", "DLL reset to done upper", gap, P_DLL + 4);
    endtask

    task automatic test_idle_after_done();
        repeat (40) @(negedge clk);
        chk(n_after_bad == 0, "R10", "activity after done", n_after_bad, 0);
        chk(init_done === 1'b1 && cke === 1'b1, "R10", "done and cke held",
            int'({init_done, cke}), 3);
    endtask

    task automatic test_mid_reset();
        repeat (P_PWR + 12) @(negedge clk);
        rst_n <= 1'b0;
        repeat (2) @(negedge clk);
        chk(cke === 1'b0 && init_done === 1'b0, "R1", "mid-run reset clears",
            int'({cke, init_done}), 0);
        rst_n <= 1'b1;
        wait_done();
        chk(n_low == P_PWR, "R1", "restart cke-low cycles", n_low, P_PWR);
        chk(n_log == 5 + P_REF, "R3", "restart command count", n_log, 5 + P_REF);
    endtask

    initial begin
        #(20 * 20000);
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        @(negedge clk);
        test_reset_state();
        wait_done();
        test_powerup();
        test_order();
        test_fields();
        test_gaps();
        test_done_timing();
        test_idle_after_done();
        @(negedge clk);
        rst_n <= 1'b0;
        @(negedge clk);
        rst_n <= 1'b1;
        test_mid_reset();
        test_fields();
        test_gaps();
        finish_run();
    end

endmodule